// File: doc/BRIEF.md
# Device Reset Sequencer with Retry

This block brings an external device out of reset under timed control. After a start pulse it pulls an active-low reset output low, holds it for a minimum time, waits for an input that reports the external reference clocks as stable, and then holds reset for one further settling interval. It then releases reset, waits for the device's internal clock synthesizer timer and the serial link to settle, and finally samples a group of status inputs to decide whether the device came up correctly.

A good result needs three things: the device's reset-timer-expired flag must be set, the serial PLL timer-expired flag must be set, and none of the monitored clock out-of-lock flags may be set. A compile-time mask chooses which out-of-lock flags count. If the check fails, the whole sequence runs again from the reset-low phase. After a set number of attempts (three by default) the block gives up. Each run ends with a one-cycle done pulse and a pass or fail flag. That flag stays set until the next start.

All intervals are given in ticks. A tick is a fixed period taken from a prescaler, and the prescaler's divide ratio comes from the clock and tick frequency parameters. The default intervals include one extra millisecond of margin on the mandatory waits.

Top module: `dev_reset_sequencer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `dev_rst_n_o` is 1 and `busy_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: A `start_i` pulse seen in idle drives `dev_rst_n_o` to 0 and `busy_o` to 1 from the next clock edge.
- R3: In every attempt, `dev_rst_n_o` stays low for at least (HOLD_TICKS + SETTLE_TICKS) tick periods.
- R4: `dev_rst_n_o` is not released until `clk_stable_i` has been seen high. Once it is high, reset stays low for at least SETTLE_TICKS more tick periods.
- R5: After `dev_rst_n_o` rises, the status inputs are judged no earlier than (SYNTH_TICKS + SERIAL_TICKS) tick periods later.
- R6: An attempt succeeds only if all three of these hold: `rst_timer_done_i` is 1, `serdes_timer_done_i` is 1, and every `lock_lost_i` bit whose `LOCK_MASK` bit is 1 is 0. Bits with a mask bit of 0 have no effect.
- R7: A failed attempt restarts the full sequence, including a new low phase on `dev_rst_n_o`. After MAX_ATTEMPTS failed attempts the run ends with `fail_o` set.
- R8: `done_o` is high for exactly one cycle per run. `pass_o` and `fail_o` are never both 1, they hold their value after done, and both are cleared by the next accepted start.
- R9: A `start_i` pulse that arrives while a run is in progress is ignored. The run keeps its attempt count and produces exactly one done pulse.
- R10: `busy_o` is 1 from the start until the done pulse, and it is 0 in the cycle of the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start_i | input | 1 | Start pulse; only has an effect when idle |
| clk_stable_i | input | 1 | External clocks and reference select are stable |
| rst_timer_done_i | input | 1 | Device reset-timer-expired status |
| lock_lost_i | input | NUM_LOCK | Device clock out-of-lock status flags |
| serdes_timer_done_i | input | 1 | Device serial PLL timer-expired status |
| dev_rst_n_o | output | 1 | Active-low reset to the device |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Sticky: the last run succeeded |
| fail_o | output | 1 | Sticky: the last run used up all attempts |

## Verification
The checks run the sequencer with several kinds of status input:
- All status good from the start, which should pass on the first attempt.
- The clock-stable input held low for a while after start. This shows whether reset release really waits for that input rather than for a fixed time.
- Each of the three failure causes (reset timer not expired, serial timer not expired, a watched lock bit set) held bad for every attempt. This must end in failure after exactly three reset pulses.
- A failure cause held for only the first one or two attempts. This shows that the retry count and the final result track the attempt in which the status became good.
- A lock bit that is masked out and always set. This separates ignored flags from watched ones.
- A second start pulse in the middle of a run. This must not add a done pulse or a reset pulse.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_HOLD     = 3'd1,
        SEQ_WAIT_CLK = 3'd2,
        SEQ_SETTLE   = 3'd3,
        SEQ_SYNTH    = 3'd4,
        SEQ_SERIAL   = 3'd5,
        SEQ_CHECK    = 3'd6
    } seq_state_e;

    // Prescaler ratio; never below one cycle per tick.
    function automatic int unsigned cycles_per_tick(input int unsigned clk_hz,
                                                    input int unsigned tick_hz);
        int unsigned r;
        r = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rst_seq_tick.sv
module rst_seq_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && !clear_i) |=> !tick_o) else $error("tick repeated"); // R3
        end
    endgenerate

endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] ticks_i,
    input  logic          tick_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = ticks_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0)) else $error("timer wrapped"); // R3

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q)) else $error("timer moved without tick"); // R5

endmodule

// File: rtl/rst_seq_judge.sv
module rst_seq_judge #(
    parameter int unsigned          NUM_LOCK  = 4,
    parameter logic [NUM_LOCK-1:0]  LOCK_MASK = '1
) (
    input  logic                rst_timer_done_i,
    input  logic [NUM_LOCK-1:0] lock_lost_i,
    input  logic                serdes_timer_done_i,
    output logic                good_o
);
    logic [NUM_LOCK-1:0] watched;

    generate
        for (genvar i = 0; i < NUM_LOCK; i++) begin : g_lock
            if (LOCK_MASK[i]) begin : g_on
                assign watched[i] = lock_lost_i[i];
            end else begin : g_off
                assign watched[i] = 1'b0;
            end
        end
    endgenerate

    assign good_o = rst_timer_done_i && serdes_timer_done_i && (watched == '0);

endmodule

// File: rtl/dev_reset_sequencer.sv
module dev_reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter int unsigned         CLK_HZ       = 250_000_000,
    parameter int unsigned         TICK_HZ      = 10_000,
    parameter int unsigned         HOLD_TICKS   = 10,
    parameter int unsigned         SETTLE_TICKS = 20,
    parameter int unsigned         SYNTH_TICKS  = 150,
    parameter int unsigned         SERIAL_TICKS = 2,
    parameter int unsigned         MAX_ATTEMPTS = 3,
    parameter int unsigned         NUM_LOCK     = 4,
    parameter logic [NUM_LOCK-1:0] LOCK_MASK    = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                clk_stable_i,
    input  logic                rst_timer_done_i,
    input  logic [NUM_LOCK-1:0] lock_lost_i,
    input  logic                serdes_timer_done_i,
    output logic                dev_rst_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                pass_o,
    output logic                fail_o
);
    localparam int unsigned DIV    = cycles_per_tick(CLK_HZ, TICK_HZ);
    localparam int unsigned MAXT   = max_of4(HOLD_TICKS, SETTLE_TICKS, SYNTH_TICKS, SERIAL_TICKS);
    localparam int unsigned TW     = $clog2(MAXT + 1);
    localparam int unsigned ATT_W  = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
    localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(MAX_ATTEMPTS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [ATT_W-1:0] attempt;
        logic             done;
        logic             pass;
        logic             fail;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic          load_d;
    logic [TW-1:0] load_val_d;
    logic          tick;
    logic          expired;
    logic          status_good;

    rst_seq_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_d),
        .tick_o  (tick)
    );

    rst_seq_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_d),
        .ticks_i   (load_val_d),
        .tick_i    (tick),
        .expired_o (expired)
    );

    rst_seq_judge #(.NUM_LOCK(NUM_LOCK), .LOCK_MASK(LOCK_MASK)) u_judge (
        .rst_timer_done_i    (rst_timer_done_i),
        .lock_lost_i         (lock_lost_i),
        .serdes_timer_done_i (serdes_timer_done_i),
        .good_o              (status_good)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        load_d     = 1'b0;
        load_val_d = '0;
        unique case (cur_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    nxt_d.state   = SEQ_HOLD;
                    nxt_d.attempt = '0;
                    nxt_d.pass    = 1'b0;
                    nxt_d.fail    = 1'b0;
                    load_d        = 1'b1;
                    load_val_d    = TW'(HOLD_TICKS);
                end
            end
            SEQ_HOLD: begin
                if (expired) nxt_d.state = SEQ_WAIT_CLK;
            end
            SEQ_WAIT_CLK: begin
                if (clk_stable_i) begin
                    nxt_d.state = SEQ_SETTLE;
                    load_d      = 1'b1;
                    load_val_d  = TW'(SETTLE_TICKS);
                end
            end
            SEQ_SETTLE: begin
                if (expired) begin
                    nxt_d.state = SEQ_SYNTH;
                    load_d      = 1'b1;
                    load_val_d  = TW'(SYNTH_TICKS);
                end
            end
            SEQ_SYNTH: begin
                if (expired) begin
                    nxt_d.state = SEQ_SERIAL;
                    load_d      = 1'b1;
                    load_val_d  = TW'(SERIAL_TICKS);
                end
            end
            SEQ_SERIAL: begin
                if (expired) nxt_d.state = SEQ_CHECK;
            end
            SEQ_CHECK: begin
                if (status_good) begin
                    nxt_d.state = SEQ_IDLE;
                    nxt_d.pass  = 1'b1;
                    nxt_d.done  = 1'b1;
                end else if (cur_q.attempt == LAST_ATT) begin
                    nxt_d.state = SEQ_IDLE;
                    nxt_d.fail  = 1'b1;
                    nxt_d.done  = 1'b1;
                end else begin
                    nxt_d.state   = SEQ_HOLD;
                    nxt_d.attempt = cur_q.attempt + 1'b1;
                    load_d        = 1'b1;
                    load_val_d    = TW'(HOLD_TICKS);
                end
            end
            default: begin
                nxt_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= SEQ_IDLE;
            cur_q.attempt <= '0;
            cur_q.done    <= 1'b0;
            cur_q.pass    <= 1'b0;
            cur_q.fail    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dev_rst_n_o = !(cur_q.state == SEQ_HOLD ||
                           cur_q.state == SEQ_WAIT_CLK ||
                           cur_q.state == SEQ_SETTLE);
    assign busy_o = (cur_q.state != SEQ_IDLE);
    assign done_o = cur_q.done;
    assign pass_o = cur_q.pass;
    assign fail_o = cur_q.fail;

    AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n_o) |-> ($past(cur_q.state) == SEQ_SETTLE && $past(expired)))
        else $error("reset released early"); // R3

    AST_CLK_STABLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == SEQ_SETTLE && $past(cur_q.state) == SEQ_WAIT_CLK) |-> $past(clk_stable_i))
        else $error("settle entered without stable clocks"); // R4

    AST_PASS_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> $past(rst_timer_done_i && serdes_timer_done_i &&
                                ((lock_lost_i & LOCK_MASK) == '0)))
        else $error("pass without good status"); // R6

    AST_ATTEMPT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.attempt <= LAST_ATT) else $error("attempt count overrun"); // R7

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o)) else $error("pass and fail together"); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cur_q.state != SEQ_CHECK) |=> busy_o)
        else $error("start during run ended it"); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o) else $error("done while busy"); // R10

endmodule

// File: tb/dev_reset_sequencer_tb.sv
module dev_reset_sequencer_tb;

    localparam int unsigned DIV          = 4;
    localparam int unsigned HOLD_TICKS   = 3;
    localparam int unsigned SETTLE_TICKS = 4;
    localparam int unsigned SYNTH_TICKS  = 6;
    localparam int unsigned SERIAL_TICKS = 2;
    localparam int unsigned MAX_ATT      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       clk_stable_i = 1'b0;
    logic       rst_timer_done_i = 1'b0;
    logic [3:0] lock_lost_i = 4'b0;
    logic       serdes_timer_done_i = 1'b0;
    logic       dev_rst_n_o, busy_o, done_o, pass_o, fail_o;

    always #2 clk = ~clk;

    dev_reset_sequencer #(
        .CLK_HZ(1_000_000), .TICK_HZ(250_000),
        .HOLD_TICKS(HOLD_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
        .SYNTH_TICKS(SYNTH_TICKS), .SERIAL_TICKS(SERIAL_TICKS),
        .MAX_ATTEMPTS(MAX_ATT), .NUM_LOCK(4), .LOCK_MASK(4'b1011)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_stable_i(clk_stable_i),
        .rst_timer_done_i(rst_timer_done_i), .lock_lost_i(lock_lost_i),
        .serdes_timer_done_i(serdes_timer_done_i), .dev_rst_n_o(dev_rst_n_o),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
    );

    typedef struct { bit pass; int att; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int falls = 0;
    int done_cnt = 0;
    int low_len = 0;
    int stab_len = 0;
    int high_len = 0;
    bit prev_rst = 1'b1;
    bit prev_done = 1'b0;
    int cycles = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dev_rst_n_o && prev_rst) falls++;
            if (!dev_rst_n_o) begin
                low_len++;
                if (clk_stable_i) stab_len++;
                if (!busy_o) chk(1'b0, "R10 busy during reset", 0, 1);
            end
            if (dev_rst_n_o && !prev_rst) begin
                chk(low_len >= int'((HOLD_TICKS + SETTLE_TICKS) * DIV), "R3 low time",
                    low_len, (HOLD_TICKS + SETTLE_TICKS) * DIV);
                chk(stab_len >= int'(SETTLE_TICKS * DIV), "R4 low after stable",
                    stab_len, SETTLE_TICKS * DIV);
                low_len = 0;
                stab_len = 0;
                high_len = 0;
            end
            if (dev_rst_n_o && busy_o) high_len++;
            if (done_o) begin
                exp_t e;
                chk(!prev_done, "R8 done width", 2, 1);
                chk(!busy_o, "R10 busy at done", busy_o, 0);
                chk(high_len >= int'((SYNTH_TICKS + SERIAL_TICKS) * DIV), "R5 settle time",
                    high_len, (SYNTH_TICKS + SERIAL_TICKS) * DIV);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(pass_o == e.pass, "R6 pass result", pass_o, e.pass);
                    chk(fail_o == !e.pass, "R7 fail result", fail_o, !e.pass);
                    chk(falls == e.att, "R7 attempt count", falls, e.att);
                end
                falls = 0;
                high_len = 0;
                done_cnt++;
            end
            prev_done = done_o;
            prev_rst = dev_rst_n_o;
        end
    end

    // Driver: bad_n attempts fail with cause kind, then status turns good.
    task automatic run(input int bad_n, input int kind, input int stab_delay,
                       input bit masked_noise, input bit poke);
        exp_t e;
        int   seen;
        int   n;
        e.pass = (bad_n < int'(MAX_ATT));
        e.att  = e.pass ? bad_n + 1 : int'(MAX_ATT);
        exp_q.push_back(e);
        seen = done_cnt;
        clk_stable_i = (stab_delay == 0);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(dev_rst_n_o == 1'b0, "R2 reset asserted", dev_rst_n_o, 0);
        chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
        chk(!pass_o && !fail_o, "R8 result cleared", {pass_o, fail_o}, 0);
        n = 0;
        while (done_cnt == seen) begin
            bit bad;
            bad = (falls <= bad_n);
            rst_timer_done_i    = !(bad && kind == 0);
            serdes_timer_done_i = !(bad && kind == 2);
            lock_lost_i = (masked_noise ? 4'b0100 : 4'b0000)
                        | ((bad && kind == 1) ? 4'b0001 : 4'b0000)
                        | ((bad && kind == 3) ? 4'b1000 : 4'b0000);
            if (n == stab_delay) clk_stable_i = 1'b1;
            start_i = (poke && (n == 10 || n == 40));
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(pass_o == e.pass && fail_o == !e.pass, "R8 sticky result",
            {pass_o, fail_o}, {e.pass, !e.pass});
        chk(dev_rst_n_o == 1'b1, "R7 released after run", dev_rst_n_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dev_rst_n_o == 1'b1 && !busy_o && !done_o && !pass_o && !fail_o,
            "R1 reset state", {dev_rst_n_o, busy_o, done_o, pass_o, fail_o}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_rst_n_o == 1'b1 && !busy_o && !pass_o && !fail_o,
            "R1 after reset", {dev_rst_n_o, busy_o, pass_o, fail_o}, 4'b1000);
        run(0, 0, 0, 1'b0, 1'b0);     // R6 clean pass
        run(0, 0, 37, 1'b0, 1'b0);    // R4 late stable clocks
        run(3, 0, 0, 1'b0, 1'b0);     // R7 reset timer never expires
        run(1, 1, 0, 1'b0, 1'b0);     // R7 lock lost once then good
        run(2, 2, 0, 1'b0, 1'b0);     // R7 serial timer late twice
        run(3, 3, 0, 1'b0, 1'b0);     // R6 watched lock bit 3
        run(0, 0, 0, 1'b1, 1'b0);     // R6 masked bit ignored
        run(3, 2, 0, 1'b0, 1'b0);     // R6 serial timer never expires
        run(0, 0, 0, 1'b0, 1'b1);     // R9 start during run
        run(1, 0, 5, 1'b1, 1'b1);     // R9 with retry
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all runs completed", exp_q.size(), 0);
        chk(!done_o && !busy_o, "R9 no extra run", {done_o, busy_o}, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule